// File: doc/BRIEF.md
# Receive Buffer Scatter Engine

This engine stores one received frame into a chain of buffers that software has laid out in memory. When a frame starts on the byte stream, it reads the current frame descriptor and the buffer descriptor that descriptor points to. It then writes the frame bytes into that buffer's data area, and continues along the buffer chain whenever a buffer is full. Frames shorter than the minimum length are zero-padded. The four check-sequence bytes, taken from an input, follow the last frame byte and may cross into the next buffer.

Every buffer the engine touches gets a count word with flag bits. After the last buffer, the engine hands the remaining chain to the next frame descriptor and writes a completion status into the current one. It reports the outcome on one-cycle event pulses. Address filtering and the check-sequence calculation belong to the surrounding receive unit, which also supplies the descriptor address and a flag that marks group-addressed frames.

Memory reads return a big-endian halfword one cycle after the request. A halfword at address A has byte A in bits 15:8. Writes are single bytes and are always accepted. A 32-bit pointer is stored as two such halfwords, with the low half at the lower address.

Top module: `rx_scatter_engine`

## Requirements
- R1: After reset, s_ready, mem_rd_en, mem_wr_en, evt_frame, evt_suspend and evt_error are all low.
- R2: A frame starts when s_valid is seen while idle. The engine reads the frame descriptor fields before it accepts any byte: the command halfword at +2, the next-descriptor pointer at +4 and the first buffer pointer at +8. From each buffer descriptor it reads the size halfword at +12, the data address at +8 and the next-buffer pointer at +4.
- R3: A frame of fewer than MIN_FRAME (60) bytes is stored with zero bytes appended up to 60. The four bytes of rx_fcs follow, most significant byte first.
- R4: The stored byte sequence fills each buffer in address order from its data address. Each buffer receives the smaller of its size (bits 13:0 of the size halfword) and the number of bytes still to store. Check-sequence bytes may continue into the next buffer. No byte is written beyond that count.
- R5: Each used buffer gets a count halfword at its descriptor +0. Bits 13:0 hold the bytes written, bit 14 is set, and bit 15 is set only on the buffer holding the final byte. Buffers the frame did not reach keep their count halfword unchanged.
- R6: A buffer whose size halfword has bit 15 set ends the chain. If bytes remain after it, the frame is aborted as in R10.
- R7: The next-buffer pointer of the last used buffer is written as a 32-bit pointer to offset +8 of the next frame descriptor.
- R8: The frame descriptor's halfword at +0 is written with 0xA000, plus bit 0 when rx_group was high at frame start.
- R9: evt_frame pulses for one cycle right after the status write. evt_suspend pulses with it when bit 14 of the frame descriptor command halfword is set.
- R10: The frame is aborted if any of these holds: a null pointer (0xFFFFFFFF) is needed as the first buffer or the next buffer, a buffer size of zero is read, or the chain ends too early. On abort, evt_error pulses once, the remaining stream bytes up to s_last are accepted and dropped, and neither the status nor the next-descriptor pointer is written. The next frame is handled normally.
- R11: s_ready is high only while frame bytes are being stored or dropped. It is low during descriptor reads, and it is low in the cycle after the byte carrying s_last is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| rx_fd_addr | input | 32 | Address of the current frame descriptor, sampled at frame start |
| rx_group | input | 1 | Frame was broadcast or multicast, sampled at frame start |
| rx_fcs | input | 32 | Check sequence, sampled with the byte carrying s_last |
| s_valid | input | 1 | Stream byte valid |
| s_data | input | 8 | Stream byte |
| s_last | input | 1 | Marks the final byte of the frame |
| s_ready | output | 1 | Stream byte accepted when high with s_valid |
| mem_rd_en | output | 1 | Halfword read request |
| mem_rd_addr | output | 32 | Read address |
| mem_rd_data | input | 16 | Big-endian halfword, one cycle after the request |
| mem_wr_en | output | 1 | Byte write request |
| mem_wr_addr | output | 32 | Write address |
| mem_wr_data | output | 8 | Write byte |
| evt_frame | output | 1 | Frame stored and status written |
| evt_suspend | output | 1 | Descriptor asked for the receive unit to suspend |
| evt_error | output | 1 | Frame aborted |

## Verification
A wrong byte counter or wrong buffer fill count shows up within one frame in three places: the stored bytes, the count words, and the pointer handed to the next descriptor. Padding and check-sequence placement are exposed by short frames and by buffer sizes that split the check sequence. A stuck walk or a missed chain end appears as a missing or spurious evt_error, or as a status halfword left untouched, within a few hundred cycles. A stream handshake fault appears as misplaced payload or a hung stream. Random frame lengths and buffer sizes vary where the check sequence falls relative to buffer boundaries.

// File: rtl/rxs_pkg.sv
package rxs_pkg;

  localparam logic [31:0] NULL_PTR = 32'hFFFF_FFFF;
  localparam int          SIZE_W   = 14;

  typedef enum logic [4:0] {
    ST_IDLE,
    ST_FD0, ST_FD1, ST_FD2, ST_FD3, ST_FD4, ST_FD5,
    ST_BD0, ST_BD1, ST_BD2, ST_BD3, ST_BD4, ST_BD5,
    ST_DATA, ST_CNT0, ST_CNT1, ST_PTR, ST_STAT0, ST_STAT1,
    ST_FAIL, ST_DRAIN
  } rxs_state_e;

  typedef enum logic [1:0] {PH_PAY, PH_PAD, PH_FCS} rxs_phase_e;

  // buffer count word: end flag, filled flag, byte count
  function automatic logic [15:0] count_word(logic [SIZE_W-1:0] n, logic fin);
    return {fin, 1'b1, n};
  endfunction

  // completion status: complete, ok, group flag
  function automatic logic [15:0] fd_status(logic grp);
    return {4'hA, 11'd0, grp};
  endfunction

  // byte of a pointer stored as two big-endian halfwords, low half first
  function automatic logic [7:0] ptr_lane(logic [31:0] p, logic [1:0] i);
    case (i)
      2'd0:    return p[15:8];
      2'd1:    return p[7:0];
      2'd2:    return p[31:24];
      default: return p[23:16];
    endcase
  endfunction

  // check-sequence byte, most significant first
  function automatic logic [7:0] fcs_lane(logic [31:0] c, logic [1:0] i);
    return 8'(c >> (8 * (3 - int'(i))));
  endfunction

endpackage

// File: rtl/rxs_byte_src.sv
module rxs_byte_src
  import rxs_pkg::*;
#(
  parameter int MIN_FRAME = 60,
  parameter int LEN_W     = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clear,
  input  logic        adv,
  input  logic        s_valid,
  input  logic [7:0]  s_data,
  input  logic        s_last,
  input  logic [31:0] fcs_in,
  output logic        byte_valid,
  output logic [7:0]  byte_data,
  output logic        byte_final,
  output logic        in_payload
);

  localparam logic [LEN_W-1:0] MIN_LEN = LEN_W'(MIN_FRAME);

  rxs_phase_e       phase;
  logic [LEN_W-1:0] cnt;
  logic [31:0]      fcs_q;
  logic [1:0]       fidx;
  logic [LEN_W-1:0] cnt_nx;

  assign cnt_nx     = cnt + 1'b1;
  assign in_payload = (phase == PH_PAY);
  assign byte_valid = in_payload ? s_valid : 1'b1;
  assign byte_final = (phase == PH_FCS) && (fidx == 2'd3);

  always_comb begin
    case (phase)
      PH_PAY:  byte_data = s_data;
      PH_PAD:  byte_data = 8'h00;
      default: byte_data = fcs_lane(fcs_q, fidx);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_PAY;
      cnt   <= '0;
      fcs_q <= '0;
      fidx  <= '0;
    end else if (clear) begin
      phase <= PH_PAY;
      cnt   <= '0;
      fidx  <= '0;
    end else if (adv) begin
      case (phase)
        PH_PAY: begin
          cnt <= cnt_nx;
          if (s_last) begin
            fcs_q <= fcs_in;
            phase <= (cnt_nx < MIN_LEN) ? PH_PAD : PH_FCS;
          end
        end
        PH_PAD: begin
          cnt <= cnt_nx;
          if (cnt_nx >= MIN_LEN) phase <= PH_FCS;
        end
        default: fidx <= fidx + 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/rxs_buf_track.sv
module rxs_buf_track
  import rxs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              adv,
  input  logic [SIZE_W-1:0] limit,
  output logic [SIZE_W-1:0] used,
  output logic              at_limit
);

  assign at_limit = (used + 1'b1) == limit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     used <= '0;
    else if (clear) used <= '0;
    else if (adv)   used <= used + 1'b1;
  end

endmodule

// File: rtl/rx_scatter_engine.sv
module rx_scatter_engine
  import rxs_pkg::*;
#(
  parameter int MIN_FRAME = 60,
  parameter int LEN_W     = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] rx_fd_addr,
  input  logic        rx_group,
  input  logic [31:0] rx_fcs,
  input  logic        s_valid,
  input  logic [7:0]  s_data,
  input  logic        s_last,
  output logic        s_ready,
  output logic        mem_rd_en,
  output logic [31:0] mem_rd_addr,
  input  logic [15:0] mem_rd_data,
  output logic        mem_wr_en,
  output logic [31:0] mem_wr_addr,
  output logic [7:0]  mem_wr_data,
  output logic        evt_frame,
  output logic        evt_suspend,
  output logic        evt_error
);

  rxs_state_e        state;
  logic [31:0]       fd_q, nfd_q, rbd_q, baddr_q, bnext_q;
  logic [15:0]       lo_q;
  logic [SIZE_W-1:0] bsize_q;
  logic              blast_q, grp_q, susp_q, fin_q;
  logic [1:0]        widx;

  logic              byte_valid, byte_final, in_payload;
  logic [7:0]        byte_data;
  logic [SIZE_W-1:0] used;
  logic              at_limit;
  logic [31:0]       rd_ptr;
  logic [15:0]       cw;

  // named internal events
  logic start, adv, buf_done;

  assign start    = (state == ST_IDLE) && s_valid;
  assign adv      = (state == ST_DATA) && byte_valid;
  assign buf_done = adv && (at_limit || byte_final);
  assign rd_ptr   = {mem_rd_data, lo_q};
  assign cw       = count_word(used, fin_q);
  assign s_ready  = ((state == ST_DATA) && in_payload) || (state == ST_DRAIN);

  rxs_byte_src #(.MIN_FRAME(MIN_FRAME), .LEN_W(LEN_W)) i_src (
    .clk(clk), .rst_n(rst_n), .clear(start), .adv(adv),
    .s_valid(s_valid), .s_data(s_data), .s_last(s_last), .fcs_in(rx_fcs),
    .byte_valid(byte_valid), .byte_data(byte_data),
    .byte_final(byte_final), .in_payload(in_payload)
  );

  rxs_buf_track i_trk (
    .clk(clk), .rst_n(rst_n), .clear(state == ST_BD5), .adv(adv),
    .limit(bsize_q), .used(used), .at_limit(at_limit)
  );

  always_comb begin
    mem_rd_en   = 1'b1;
    mem_rd_addr = '0;
    case (state)
      ST_FD0:  mem_rd_addr = fd_q + 32'd2;
      ST_FD1:  mem_rd_addr = fd_q + 32'd4;
      ST_FD2:  mem_rd_addr = fd_q + 32'd6;
      ST_FD3:  mem_rd_addr = fd_q + 32'd8;
      ST_FD4:  mem_rd_addr = fd_q + 32'd10;
      ST_BD0:  mem_rd_addr = rbd_q + 32'd12;
      ST_BD1:  mem_rd_addr = rbd_q + 32'd8;
      ST_BD2:  mem_rd_addr = rbd_q + 32'd10;
      ST_BD3:  mem_rd_addr = rbd_q + 32'd4;
      ST_BD4:  mem_rd_addr = rbd_q + 32'd6;
      default: mem_rd_en   = 1'b0;
    endcase
  end

  always_comb begin
    mem_wr_en   = 1'b1;
    mem_wr_addr = '0;
    mem_wr_data = '0;
    case (state)
      ST_DATA: begin
        mem_wr_en   = byte_valid;
        mem_wr_addr = baddr_q + 32'(used);
        mem_wr_data = byte_data;
      end
      ST_CNT0:  begin mem_wr_addr = rbd_q;                mem_wr_data = cw[15:8]; end
      ST_CNT1:  begin mem_wr_addr = rbd_q + 32'd1;        mem_wr_data = cw[7:0]; end
      ST_PTR:   begin mem_wr_addr = nfd_q + 32'd8 + 32'(widx);
                      mem_wr_data = ptr_lane(bnext_q, widx); end
      ST_STAT0: begin mem_wr_addr = fd_q;                 mem_wr_data = fd_status(grp_q)[15:8]; end
      ST_STAT1: begin mem_wr_addr = fd_q + 32'd1;         mem_wr_data = fd_status(grp_q)[7:0]; end
      default:  mem_wr_en = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      fd_q    <= '0;  nfd_q <= '0;  rbd_q <= '0;
      baddr_q <= '0;  bnext_q <= '0; lo_q <= '0;
      bsize_q <= '0;  blast_q <= 1'b0;
      grp_q   <= 1'b0; susp_q <= 1'b0; fin_q <= 1'b0;
      widx    <= '0;
      evt_frame <= 1'b0; evt_suspend <= 1'b0; evt_error <= 1'b0;
    end else begin
      evt_frame   <= (state == ST_STAT1);
      evt_suspend <= (state == ST_STAT1) && susp_q;
      evt_error   <= ((state == ST_FAIL) && !in_payload) ||
                     ((state == ST_DRAIN) && s_valid && s_last);
      case (state)
        ST_IDLE: if (start) begin
          fd_q  <= rx_fd_addr;
          grp_q <= rx_group;
          state <= ST_FD0;
        end
        ST_FD0: state <= ST_FD1;
        ST_FD1: begin susp_q <= mem_rd_data[14]; state <= ST_FD2; end
        ST_FD2: begin lo_q <= mem_rd_data;       state <= ST_FD3; end
        ST_FD3: begin nfd_q <= rd_ptr;           state <= ST_FD4; end
        ST_FD4: begin lo_q <= mem_rd_data;       state <= ST_FD5; end
        ST_FD5: begin
          rbd_q <= rd_ptr;
          state <= (rd_ptr == NULL_PTR) ? ST_FAIL : ST_BD0;
        end
        ST_BD0: state <= ST_BD1;
        ST_BD1: begin
          bsize_q <= mem_rd_data[SIZE_W-1:0];
          blast_q <= mem_rd_data[15];
          state   <= ST_BD2;
        end
        ST_BD2: begin lo_q <= mem_rd_data;       state <= ST_BD3; end
        ST_BD3: begin baddr_q <= rd_ptr;         state <= ST_BD4; end
        ST_BD4: begin lo_q <= mem_rd_data;       state <= ST_BD5; end
        ST_BD5: begin
          bnext_q <= rd_ptr;
          state   <= (bsize_q == '0) ? ST_FAIL : ST_DATA;
        end
        ST_DATA: if (buf_done) begin
          fin_q <= byte_final;
          state <= ST_CNT0;
        end
        ST_CNT0: state <= ST_CNT1;
        ST_CNT1: begin
          widx <= '0;
          if (fin_q)                     state <= ST_PTR;
          else if (blast_q)              state <= ST_FAIL;
          else if (bnext_q == NULL_PTR)  state <= ST_FAIL;
          else begin
            rbd_q <= bnext_q;
            state <= ST_BD0;
          end
        end
        ST_PTR: begin
          widx <= widx + 1'b1;
          if (widx == 2'd3) state <= ST_STAT0;
        end
        ST_STAT0: state <= ST_STAT1;
        ST_STAT1: state <= ST_IDLE;
        ST_FAIL:  state <= in_payload ? ST_DRAIN : ST_IDLE;
        ST_DRAIN: if (s_valid && s_last) state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rx_scatter_chk.sv
module rx_scatter_chk (
  input logic clk,
  input logic rst_n,
  input logic s_valid,
  input logic s_ready,
  input logic s_last,
  input logic mem_rd_en,
  input logic mem_wr_en,
  input logic evt_frame,
  input logic evt_suspend,
  input logic evt_error,
  input logic buf_done
);

  // R11
  rd_blocks_stream_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> !s_ready);

  // R11
  last_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready && s_last) |=> !s_ready);

  // R9
  suspend_with_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_suspend |-> evt_frame);

  // R9
  frame_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_frame |-> $past(mem_wr_en));

  // R10
  outcome_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(evt_frame && evt_error));

  // R5
  count_follows_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_done |=> mem_wr_en);

endmodule

bind rx_scatter_engine rx_scatter_chk i_chk (
  .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
  .s_last(s_last), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
  .evt_frame(evt_frame), .evt_suspend(evt_suspend), .evt_error(evt_error),
  .buf_done(buf_done)
);

// File: tb/test_rx_scatter_engine.sv
module test_rx_scatter_engine;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] rx_fd_addr = 32'h100;
  logic        rx_group = 1'b0;
  logic [31:0] rx_fcs = '0;
  logic        s_valid = 1'b0;
  logic [7:0]  s_data = '0;
  logic        s_last = 1'b0;
  logic        s_ready;
  logic        mem_rd_en, mem_wr_en;
  logic [31:0] mem_rd_addr, mem_wr_addr;
  logic [15:0] mem_rd_data = '0;
  logic [7:0]  mem_wr_data;
  logic        evt_frame, evt_suspend, evt_error;

  always #2.5 clk = ~clk;

  rx_scatter_engine i_rx_scatter_engine (
    .clk(clk), .rst_n(rst_n), .rx_fd_addr(rx_fd_addr), .rx_group(rx_group),
    .rx_fcs(rx_fcs), .s_valid(s_valid), .s_data(s_data), .s_last(s_last),
    .s_ready(s_ready), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_data(mem_rd_data), .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr),
    .mem_wr_data(mem_wr_data), .evt_frame(evt_frame), .evt_suspend(evt_suspend),
    .evt_error(evt_error)
  );

  logic [7:0] mem [0:4095];

  always @(posedge clk) begin
    if (mem_wr_en) mem[mem_wr_addr[11:0]] <= mem_wr_data;
    if (mem_rd_en) mem_rd_data <= {mem[mem_rd_addr[11:0]], mem[mem_rd_addr[11:0] + 12'd1]};
  end

  int n_chk = 0, n_err = 0;
  int n_frame = 0, n_susp = 0, n_fail = 0;

  always @(negedge clk) if (rst_n) begin
    if (evt_frame)   n_frame++;
    if (evt_suspend) n_susp++;
    if (evt_error)   n_fail++;
  end

  logic [15:0] bsz [4];
  logic [31:0] bnx [4];
  logic [7:0]  pay [256];
  int          flen;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr16(int a, logic [15:0] v);
    mem[a] = v[15:8]; mem[a+1] = v[7:0];
  endtask
  task automatic wr32(int a, logic [31:0] v);
    wr16(a, v[15:0]); wr16(a + 2, v[31:16]);
  endtask
  function automatic logic [15:0] rd16(int a);
    return {mem[a], mem[a+1]};
  endfunction
  function automatic logic [31:0] rd32(int a);
    return {rd16(a + 2), rd16(a)};
  endfunction

  function automatic logic [7:0] exp_byte(int k);
    int pl = (flen < 60) ? 60 : flen;
    if (k < flen) return pay[k];
    if (k < pl)   return 8'h00;
    return 8'(rx_fcs >> (8 * (3 - (k - pl))));
  endfunction

  task automatic default_chain();
    for (int i = 0; i < 4; i++) bnx[i] = 32'h300 + 32'(16 * (i + 1));
  endtask

  task automatic setup(logic [15:0] cmd, logic [31:0] first_rbd);
    for (int a = 12'h800; a < 12'hC00; a++) mem[a] = 8'hEE;
    wr16(12'h100, 16'h1111);
    wr16(12'h102, cmd);
    wr32(12'h104, 32'h200);
    wr32(12'h108, first_rbd);
    wr32(12'h208, 32'h1234_5678);
    for (int i = 0; i < 4; i++) begin
      wr16(12'h300 + 16 * i, 16'h0000);
      wr32(12'h304 + 16 * i, bnx[i]);
      wr32(12'h308 + 16 * i, 32'h800 + 32'(256 * i));
      wr16(12'h30C + 16 * i, bsz[i]);
    end
  endtask

  task automatic send();
    int i = 0;
    bit first = 1'b1;
    while (i < flen) begin
      @(negedge clk);
      s_valid = 1'b1; s_data = pay[i]; s_last = (i == flen - 1);
      if (first) begin
        chk("R11", "ready at frame start", 32'(s_ready), 32'd0);
        first = 1'b0;
      end
      if (s_ready) i++;
    end
    @(negedge clk);
    s_valid = 1'b0; s_last = 1'b0;
    chk("R11", "ready after last byte", 32'(s_ready), 32'd0);
  endtask

  task automatic run_frame(output int f0, output int e0, output int p0);
    f0 = n_frame; e0 = n_fail; p0 = n_susp;
    send();
    for (int t = 0; t < 3000 && n_frame == f0 && n_fail == e0; t++) @(posedge clk);
    repeat (3) @(posedge clk);
  endtask

  task automatic check_good(logic [15:0] cmd, string tag);
    int f0, e0, p0, rem, k, bad, last_used;
    run_frame(f0, e0, p0);
    rem = ((flen < 60) ? 60 : flen) + 4;
    k = 0; bad = 0; last_used = -1;
    for (int i = 0; i < 4; i++) begin
      int sz, u;
      if (rem == 0) break;
      sz = int'(bsz[i][13:0]);
      u  = (sz < rem) ? sz : rem;
      for (int j = 0; j < u; j++) begin
        if (mem[12'h800 + 256 * i + j] !== exp_byte(k)) bad++;
        k++;
      end
      if (u < sz && mem[12'h800 + 256 * i + u] !== 8'hEE) bad++;
      rem -= u;
      chk("R5", {tag, " count word"}, 32'(rd16(12'h300 + 16 * i)),
          32'({(rem == 0), 1'b1, 14'(u)}));
      last_used = i;
      if (bsz[i][15]) break;
    end
    chk("R2 R3 R4", {tag, " stored bytes mismatching"}, 32'(bad), 32'd0);
    for (int i = last_used + 1; i < 4; i++)
      chk("R5", {tag, " unreached count word"}, 32'(rd16(12'h300 + 16 * i)), 32'd0);
    chk("R7", {tag, " next descriptor pointer"}, rd32(12'h208), bnx[last_used]);
    chk("R8", {tag, " status"}, 32'(rd16(12'h100)), 32'({4'hA, 11'd0, rx_group}));
    chk("R9", {tag, " frame events"}, 32'(n_frame - f0), 32'd1);
    chk("R9", {tag, " suspend events"}, 32'(n_susp - p0), 32'(cmd[14]));
    chk("R10", {tag, " no error"}, 32'(n_fail - e0), 32'd0);
  endtask

  task automatic check_bad(string tag);
    int f0, e0, p0;
    run_frame(f0, e0, p0);
    chk("R10", {tag, " error event"}, 32'(n_fail - e0), 32'd1);
    chk("R10", {tag, " no frame event"}, 32'(n_frame - f0), 32'd0);
    chk("R10", {tag, " status untouched"}, 32'(rd16(12'h100)), 32'h1111);
    chk("R10", {tag, " pointer untouched"}, rd32(12'h208), 32'h1234_5678);
  endtask

  task automatic fill_payload(int n);
    flen = n;
    for (int i = 0; i < 256; i++) pay[i] = 8'($urandom);
    rx_fcs = $urandom;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int a = 0; a < 4096; a++) mem[a] = 8'h00;
    repeat (3) @(negedge clk);
    chk("R1", "s_ready in reset", 32'(s_ready), 32'd0);
    chk("R1", "memory idle in reset", 32'({mem_rd_en, mem_wr_en}), 32'd0);
    chk("R1", "events in reset", 32'({evt_frame, evt_suspend, evt_error}), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "idle after reset", 32'({s_ready, mem_rd_en, mem_wr_en}), 32'd0);

    // R3: short frame padded, single last buffer, group frame
    default_chain();
    bsz = '{16'h8000 | 16'd200, 16'd50, 16'd50, 16'd50};
    fill_payload(20); rx_group = 1'b1;
    setup(16'h0000, 32'h300); check_good(16'h0000, "short");

    // R4: check sequence straddles two buffers
    bsz = '{16'd72, 16'h8000 | 16'd100, 16'd50, 16'd50};
    fill_payload(70); rx_group = 1'b0;
    setup(16'h0000, 32'h300); check_good(16'h0000, "straddle");

    // R5 R7: exact fit ends on a non-final buffer; R9 suspend
    bsz = '{16'd64, 16'h8000 | 16'd50, 16'd50, 16'd50};
    fill_payload(60);
    setup(16'h4000, 32'h300); check_good(16'h4000, "exactfit");

    // R10: null first buffer pointer
    fill_payload(30);
    setup(16'h0000, 32'hFFFF_FFFF); check_bad("nullfirst");

    // R10: zero-size second buffer
    bsz = '{16'd10, 16'd0, 16'd50, 16'd50};
    fill_payload(40);
    setup(16'h0000, 32'h300); check_bad("zerosize");

    // R6: chain ends before frame does
    bsz = '{16'h8000 | 16'd20, 16'd50, 16'd50, 16'd50};
    fill_payload(40);
    setup(16'h0000, 32'h300); check_bad("overflow");

    // R10: null next-buffer pointer when needed
    bsz = '{16'd10, 16'd50, 16'd50, 16'd50};
    bnx[0] = 32'hFFFF_FFFF;
    fill_payload(40);
    setup(16'h0000, 32'h300); check_bad("nullnext");
    default_chain();

    // R10: recovery, then random frames
    for (int n = 0; n < 40; n++) begin
      logic [15:0] cmd;
      for (int i = 0; i < 3; i++) bsz[i] = 16'(8 + $urandom % 73);
      bsz[3] = 16'h8000 | 16'd200;
      fill_payload(1 + int'($urandom % 150));
      rx_group = 1'($urandom);
      cmd = ($urandom % 4 == 0) ? 16'h4000 : 16'h0000;
      setup(cmd, 32'h300);
      check_good(cmd, "random");
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule